// File: doc/BRIEF.md
# Match-Channel Interval Timer

This block keeps a 32-bit counter that climbs by one on each cycle its tick input is high and rolls over to zero after the all-ones value. Four compare channels each hold a 32-bit target. When the counter steps onto a channel's target, that channel latches a sticky flag. A per-channel enable mask turns a latched flag into a level interrupt request.

Software reaches every register over a small single-cycle register bus. It can load the counter with any value, program each target on its own, clear flags by writing ones, and gate the requests. Periodic events need no reload logic. Because equality is tested against a wrapping counter, software adds a fixed period to a channel's target each time it fires, and the event keeps working when the sum passes the 32-bit limit.

Top module: `tick_match_timer`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, the counter, all four targets, the flag register and the enable mask read as zero, and every `irq_o` bit is low.
- R2: On a clock edge where `tick_i` is high and no counter write happens, the counter rises by one, and 0xFFFFFFFF becomes 0. With `tick_i` low and no write, the counter holds its value.
- R3: A bus write to address 0 loads the counter with `bus_wdata_i`. If `tick_i` is high in the same cycle, the write takes priority.
- R4: The target of channel k (k = 0..3) lives at address 3+k. Each target is read and written independently of the others.
- R5: Flag bit k of the register at address 1 (bits [3:0], upper bits read 0) sets on the edge where a tick moves the counter onto target k. A bus load that makes the counter equal to a target does not set the flag.
- R6: A target that lies past the rollover (for example counter 0xFFFFFFFE, target 1) fires when the counter reaches it after wrapping, and does not fire on the way there.
- R7: Writing the flag register clears exactly the bits written as 1. Bits written as 0 keep their value, and writing 0x0F clears all four.
- R8: If a flag clear and a new hit on the same channel fall in one cycle, the flag remains set.
- R9: The enable mask lives at address 2, bits [3:0]. `irq_o[k]` is high exactly when flag k and enable bit k are both set.
- R10: Reading an address with no register (7) returns zero, and `bus_rdata_o` always shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable for the current cycle |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed register |
| irq_o | output | 4 | Per-channel interrupt requests |

## Verification
On every cycle the assertions check the counter step, hold and load rules, that no flag ever appears on the edge of a counter load, that a flag drops only where a one was written to clear it, and that no request is raised on a masked or unflagged channel. Only the bench's scenarios can show the things that depend on chosen values: hits after rollover, a clear and a hit falling in the same cycle, independent storage of the four targets, and the full reset image read back over the bus.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
  localparam int unsigned REG_CNT        = 0;
  localparam int unsigned REG_STS        = 1;
  localparam int unsigned REG_IE         = 2;
  localparam int unsigned REG_MATCH_BASE = 3;

  function automatic int unsigned reg_count(int unsigned n_ch);
    return REG_MATCH_BASE + n_ch;
  endfunction
endpackage

// File: rtl/tmt_counter.sv
module tmt_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] cnt_nxt_o,
  output logic              step_o
);
  logic [DATA_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + DATA_W'(1);
  // a bus load masks the tick so a loaded value never counts as a hit
  assign step_o    = tick_i & ~load_i;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (tick_i)  cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/tmt_channel.sv
module tmt_channel #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tgt_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] cnt_nxt_i,
  input  logic              clr_i,
  input  logic              en_i,
  output logic [DATA_W-1:0] tgt_o,
  output logic              flag_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] tgt_q;
  logic              flag_q;
  logic              hit;

  assign hit = step_i & (cnt_nxt_i == tgt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tgt_q <= '0;
    else if (tgt_we_i) tgt_q <= wdata_i;
  end

  // hit has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (hit)    flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign tgt_o  = tgt_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;
endmodule

// File: rtl/tmt_regdec.sv
module tmt_regdec
  import tmt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                        en_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [DATA_W-1:0]           cnt_i,
  input  logic [N_CH-1:0][DATA_W-1:0] tgt_i,
  input  logic [N_CH-1:0]             flag_i,
  input  logic [N_CH-1:0]             ie_i,
  output logic                        cnt_wr_o,
  output logic [N_CH-1:0]             tgt_we_o,
  output logic [N_CH-1:0]             clr_o,
  output logic                        ie_we_o,
  output logic [DATA_W-1:0]           rdata_o
);
  logic wr;
  assign wr = en_i & we_i;

  assign cnt_wr_o = wr & (addr_i == ADDR_W'(REG_CNT));
  assign ie_we_o  = wr & (addr_i == ADDR_W'(REG_IE));
  assign clr_o    = (wr & (addr_i == ADDR_W'(REG_STS))) ? wdata_i[N_CH-1:0] : '0;

  for (genvar k = 0; k < N_CH; k++) begin : g_tgt_dec
    assign tgt_we_o[k] = wr & (addr_i == ADDR_W'(REG_MATCH_BASE + k));
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(REG_CNT)) rdata_o = cnt_i;
    if (addr_i == ADDR_W'(REG_STS)) rdata_o = DATA_W'(flag_i);
    if (addr_i == ADDR_W'(REG_IE))  rdata_o = DATA_W'(ie_i);
    for (int k = 0; k < N_CH; k++) begin
      if (addr_i == ADDR_W'(REG_MATCH_BASE + k)) rdata_o = tgt_i[k];
    end
  end
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
  import tmt_pkg::*;
#(
  parameter  int unsigned DATA_W = 32,
  parameter  int unsigned N_CH   = 4,
  localparam int unsigned ADDR_W = $clog2(reg_count(N_CH))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [N_CH-1:0]   irq_o
);
  logic [DATA_W-1:0]           cnt_q;
  logic [DATA_W-1:0]           cnt_nxt;
  logic                        step;
  logic                        cnt_wr;
  logic                        ie_we;
  logic [N_CH-1:0]             tgt_we;
  logic [N_CH-1:0]             clr_mask;
  logic [N_CH-1:0]             sts_q;
  logic [N_CH-1:0]             ie_q;
  logic [N_CH-1:0][DATA_W-1:0] tgt_q;

  tmt_regdec #(.DATA_W(DATA_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) i_regdec (
    .en_i    (bus_en_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .cnt_i   (cnt_q),
    .tgt_i   (tgt_q),
    .flag_i  (sts_q),
    .ie_i    (ie_q),
    .cnt_wr_o(cnt_wr),
    .tgt_we_o(tgt_we),
    .clr_o   (clr_mask),
    .ie_we_o (ie_we),
    .rdata_o (bus_rdata_o)
  );

  tmt_counter #(.DATA_W(DATA_W)) i_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .load_i    (cnt_wr),
    .load_val_i(bus_wdata_i),
    .cnt_o     (cnt_q),
    .cnt_nxt_o (cnt_nxt),
    .step_o    (step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ie_q <= '0;
    else if (ie_we) ie_q <= bus_wdata_i[N_CH-1:0];
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    tmt_channel #(.DATA_W(DATA_W)) i_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tgt_we_i (tgt_we[k]),
      .wdata_i  (bus_wdata_i),
      .step_i   (step),
      .cnt_nxt_i(cnt_nxt),
      .clr_i    (clr_mask[k]),
      .en_i     (ie_q[k]),
      .tgt_o    (tgt_q[k]),
      .flag_o   (sts_q[k]),
      .irq_o    (irq_o[k])
    );
  end
endmodule

// File: rtl/tmt_checker.sv
module tmt_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_CH   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              cnt_wr,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] cnt_q,
  input logic [N_CH-1:0]   sts_q,
  input logic [N_CH-1:0]   clr_mask,
  input logic [N_CH-1:0]   ie_q,
  input logic [N_CH-1:0]   irq_o
);
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr) |=> cnt_q == $past(cnt_q) + DATA_W'(1));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_wr) |=> $stable(cnt_q));

  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> cnt_q == $past(bus_wdata_i));

  a_r5_no_flag_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (sts_q & ~$past(sts_q)) == '0);

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($past(sts_q) & ~$past(clr_mask) & ~sts_q) == '0);

  a_r9_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~(ie_q & sts_q)) == '0);
endmodule

bind tick_match_timer tmt_checker #(.DATA_W(DATA_W), .N_CH(N_CH)) i_tmt_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .cnt_wr     (cnt_wr),
  .bus_wdata_i(bus_wdata_i),
  .cnt_q      (cnt_q),
  .sts_q      (sts_q),
  .clr_mask   (clr_mask),
  .ie_q       (ie_q),
  .irq_o      (irq_o)
);

// File: tb/test_tick_match_timer.sv
`timescale 1ns/1ps
module test_tick_match_timer;
  localparam int NV = 22;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;
  // {op, addr, data, expected}
  localparam logic [68:0] VEC [NV] = '{
    {OP_RD, 3'd0, 32'h0,         32'h0},          // R1 counter
    {OP_RD, 3'd1, 32'h0,         32'h0},          // R1 flags
    {OP_WR, 3'd3, 32'h5,         32'h0},
    {OP_WR, 3'd4, 32'hA5A5_0001, 32'h0},
    {OP_WR, 3'd5, 32'h7,         32'h0},
    {OP_WR, 3'd6, 32'hFFFF_0000, 32'h0},
    {OP_RD, 3'd3, 32'h0,         32'h5},          // R4
    {OP_RD, 3'd4, 32'h0,         32'hA5A5_0001},  // R4
    {OP_RD, 3'd5, 32'h0,         32'h7},          // R4
    {OP_RD, 3'd6, 32'h0,         32'hFFFF_0000},  // R4
    {OP_TK, 3'd0, 32'd5,         32'h0},
    {OP_RD, 3'd0, 32'h0,         32'h5},          // R2
    {OP_RD, 3'd1, 32'h0,         32'h1},          // R5
    {OP_TK, 3'd0, 32'd2,         32'h0},
    {OP_RD, 3'd1, 32'h0,         32'h5},          // R5
    {OP_WR, 3'd1, 32'h1,         32'h0},
    {OP_RD, 3'd1, 32'h0,         32'h4},          // R7
    {OP_WR, 3'd1, 32'h0,         32'h0},
    {OP_RD, 3'd1, 32'h0,         32'h4},          // R7 zeros ignored
    {OP_WR, 3'd1, 32'hF,         32'h0},
    {OP_RD, 3'd1, 32'h0,         32'h0},          // R7 clear all
    {OP_RD, 3'd7, 32'h0,         32'h0}           // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        en = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tick_match_timer i_tick_match_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_en_i(en), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); en = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); en = 0; we = 0;
  endtask

  task automatic rd(string req, logic [2:0] a, logic [31:0] exp);
    @(negedge clk); addr = a; en = 1; we = 0;
    #1 check(req, rdata, exp);
    en = 0;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq in reset", 32'(irq), 32'h0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][68:67])
        OP_WR: wr(VEC[i][66:64], VEC[i][63:32]);
        OP_RD: rd($sformatf("R1/R2/R4/R5/R7/R10 table[%0d]", i), VEC[i][66:64], VEC[i][31:0]);
        default: ticks(int'(VEC[i][63:32]));
      endcase
    end

    // R8: clear and hit on channel 3 in one cycle
    wr(3'd0, 32'h1FF);
    wr(3'd6, 32'h200);
    @(negedge clk); tick = 1; en = 1; we = 1; addr = 3'd1; wdata = 32'h8;
    @(negedge clk); tick = 0; en = 0; we = 0;
    rd("R8 hit beats clear", 3'd1, 32'h8);
    // R5: load onto a target sets nothing
    wr(3'd1, 32'hF);
    wr(3'd0, 32'h200);
    rd("R5 load equal no flag", 3'd1, 32'h0);
    // R6 / R2 wrap
    wr(3'd4, 32'h1);
    wr(3'd0, 32'hFFFF_FFFE);
    ticks(1);
    rd("R2 count", 3'd0, 32'hFFFF_FFFF);
    ticks(1);
    rd("R2 wrap to zero", 3'd0, 32'h0);
    rd("R6 no early hit", 3'd1, 32'h0);
    ticks(1);
    rd("R6 hit after wrap", 3'd1, 32'h2);
    // R3 load beats tick
    @(negedge clk); tick = 1; en = 1; we = 1; addr = 3'd0; wdata = 32'h40;
    @(negedge clk); tick = 0; en = 0; we = 0;
    rd("R3 load over tick", 3'd0, 32'h40);
    repeat (3) @(negedge clk);
    rd("R2 hold", 3'd0, 32'h40);
    // R9 gating, flag bit1 set
    #1 check("R9 masked", 32'(irq), 32'h0);
    wr(3'd2, 32'h2);
    #1 check("R9 enabled", 32'(irq), 32'h2);
    rd("R9 mask readback", 3'd2, 32'h2);
    wr(3'd2, 32'hD);
    #1 check("R9 other bits", 32'(irq), 32'h0);
    wr(3'd2, 32'hF);
    #1 check("R9 all enabled", 32'(irq), 32'h2);
    wr(3'd1, 32'h2);
    #1 check("R9 flag cleared", 32'(irq), 32'h0);
    // R1 reset mid-run
    wr(3'd0, 32'h4);
    ticks(1);
    #1 check("R9 ch0 request", 32'(irq), 32'h1);
    @(negedge clk); rst_n = 0;
    #1 check("R1 irq low in reset", 32'(irq), 32'h0);
    @(negedge clk); @(negedge clk); rst_n = 1;
    rd("R1 counter", 3'd0, 32'h0);
    rd("R1 flags", 3'd1, 32'h0);
    rd("R1 mask", 3'd2, 32'h0);
    rd("R1 target0", 3'd3, 32'h0);
    rd("R1 target3", 3'd6, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule